// File: doc/BRIEF.md
# Peripheral Control Register Bank

This block is the miscellaneous I/O corner of a small processor bus. The bus presents a 32-bit address, four byte write enables, 32-bit write data and gets back combinational read data plus a pause signal. Any cycle with at least one byte enable set is a write. A cycle with none set is a read. Only addresses whose top nibble is 0x2 reach the block. Inside that region, address bits 7:4 pick one of six registers. All other address bits are ignored.

The bank fronts a serial port through two valid/ready streams. In the transmit stream the block is the source: a write to the serial data register raises `uart_tx_valid`. While `uart_tx_ready` is low the block asserts `bus_pause`, so the processor holds the same write until the transfer completes in the cycle where valid and ready are both high. In the receive stream the block is the sink: a read of the same register raises `uart_rx_ready`. The received byte transfers in any cycle where `uart_rx_valid` is also high.

The bank also holds an interrupt mask and drives a single interrupt request. It drives a 32-bit output port that software changes only by setting or clearing bits. It samples a 32-bit input port once per clock.

Top module: `periph_regbank`

## Requirements
- R1: When `bus_addr[31:28]` is not 0x2, `bus_rdata` is zero, `uart_tx_valid` and `uart_rx_ready` are low, and writes change no register.
- R2: A write at index 0 raises `uart_tx_valid` in the same cycle, and `uart_tx_data` equals `bus_wdata[7:0]`.
- R3: `bus_pause` is high exactly when a write at index 0 meets `uart_tx_ready` low. It drops in the same cycle that `uart_tx_ready` rises.
- R4: A read at index 0 raises `uart_rx_ready` and returns `uart_rx_data` zero-extended to 32 bits.
- R5: A write at index 1 stores `bus_wdata[7:0]` as the interrupt mask from the next clock edge. A read at index 1 returns the mask zero-extended.
- R6: A read at index 2 returns the status vector zero-extended. The status vector has `uart_rx_valid` in bit 0, `uart_tx_ready` in bit 1 and `irq_ext[5:0]` in bits 7:2. A write at index 2 changes neither the mask nor the output port.
- R7: `irq` is high exactly when some status bit and the same mask bit are both 1.
- R8: A write at index 3 sets, from the next edge, each `gpio_out` bit whose write-data bit is 1 and leaves the other bits unchanged.
- R9: A write at index 4 clears, from the next edge, each `gpio_out` bit whose write-data bit is 1 and leaves the other bits unchanged.
- R10: A read at index 5 returns the value `gpio_in` had at the most recent clock edge.
- R11: Indices 6 to 15 read as zero, and writes to them change neither the mask nor the output port.
- R12: Synchronous active-high `rst` clears the mask, the output port and the input sample to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Bus byte address |
| bus_byte_we | input | 4 | Byte write enables; nonzero means write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| bus_pause | output | 1 | Holds the processor while a serial write waits |
| uart_tx_valid | output | 1 | Transmit byte offered |
| uart_tx_ready | input | 1 | Transmitter can take a byte |
| uart_tx_data | output | 8 | Transmit byte |
| uart_rx_valid | input | 1 | Received byte available |
| uart_rx_ready | output | 1 | Received byte taken by a read |
| uart_rx_data | input | 8 | Received byte |
| irq_ext | input | 6 | Extra interrupt status sources |
| irq | output | 1 | Interrupt request |
| gpio_out | output | 32 | Output port |
| gpio_in | input | 32 | Input port |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, an 8-bit interrupt vector and a 32-bit port. At this width, random set and clear masks reach every output bit, including bit 31 at the top of the port. Random stimulus also reaches status bits 7:2, which come from the extra sources. Random mask and status patterns exercise both a lone matching bit and no matching bit for the interrupt. Directed cases cover a stalled serial write, addresses outside the region, the read-only and unmapped indices, and reset with all bits set.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam logic [3:0] REGION_ID = 4'h2;
  localparam int NUM_REGS = 6;
  localparam int IDX_UART = 0;
  localparam int IDX_MASK = 1;
  localparam int IDX_STAT = 2;
  localparam int IDX_SET  = 3;
  localparam int IDX_CLR  = 4;
  localparam int IDX_GIN  = 5;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
(
  input  logic [31:0]         addr,
  input  logic [3:0]          byte_we,
  output logic                in_region,
  output logic                wr,
  output logic [NUM_REGS-1:0] sel
);
  logic [3:0] idx;
  assign in_region = (addr[31:28] == REGION_ID);
  assign idx = addr[7:4];
  assign wr = |byte_we;
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel[i] = in_region && (idx == 4'(i));
  end
endmodule

// File: rtl/regbank_irq.sv
module regbank_irq #(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_wdata,
  input  logic [IRQ_W-1:0] status,
  output logic [IRQ_W-1:0] mask_q,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end
  assign irq = |(status & mask_q);
endmodule

// File: rtl/regbank_gpio.sv
module regbank_gpio #(
  parameter int GPIO_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [GPIO_W-1:0] wbits,
  input  logic [GPIO_W-1:0] pins_in,
  output logic [GPIO_W-1:0] out_q,
  output logic [GPIO_W-1:0] in_q
);
  for (genvar i = 0; i < GPIO_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) out_q[i] <= 1'b0;
      else if (set_we && wbits[i]) out_q[i] <= 1'b1;
      else if (clr_we && wbits[i]) out_q[i] <= 1'b0;
    end
  end
  always_ff @(posedge clk) begin
    if (rst) in_q <= '0;
    else in_q <= pins_in;
  end
endmodule

// File: rtl/periph_regbank.sv
module periph_regbank
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 8,
  parameter int GPIO_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       bus_addr,
  input  logic [3:0]        bus_byte_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_pause,
  output logic              uart_tx_valid,
  input  logic              uart_tx_ready,
  output logic [BYTE_W-1:0] uart_tx_data,
  input  logic              uart_rx_valid,
  output logic              uart_rx_ready,
  input  logic [BYTE_W-1:0] uart_rx_data,
  input  logic [IRQ_W-3:0]  irq_ext,
  output logic              irq,
  output logic [GPIO_W-1:0] gpio_out,
  input  logic [GPIO_W-1:0] gpio_in
);
  logic                in_region;
  logic                wr;
  logic [NUM_REGS-1:0] sel;
  logic [IRQ_W-1:0]    status;
  logic [IRQ_W-1:0]    mask_q;
  logic [GPIO_W-1:0]   in_q;

  regbank_decode u_dec (
    .addr(bus_addr), .byte_we(bus_byte_we),
    .in_region(in_region), .wr(wr), .sel(sel)
  );

  assign status = {irq_ext, uart_tx_ready, uart_rx_valid};

  regbank_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk(clk), .rst(rst),
    .mask_we(wr && sel[IDX_MASK]),
    .mask_wdata(bus_wdata[IRQ_W-1:0]),
    .status(status), .mask_q(mask_q), .irq(irq)
  );

  regbank_gpio #(.GPIO_W(GPIO_W)) u_gpio (
    .clk(clk), .rst(rst),
    .set_we(wr && sel[IDX_SET]),
    .clr_we(wr && sel[IDX_CLR]),
    .wbits(bus_wdata[GPIO_W-1:0]),
    .pins_in(gpio_in),
    .out_q(gpio_out), .in_q(in_q)
  );

  assign uart_tx_valid = wr && sel[IDX_UART];
  assign uart_tx_data  = bus_wdata[BYTE_W-1:0];
  assign bus_pause     = uart_tx_valid && !uart_tx_ready;
  assign uart_rx_ready = !wr && sel[IDX_UART];

  always_comb begin
    bus_rdata = '0;
    if (sel[IDX_UART])      bus_rdata = DATA_W'(uart_rx_data);
    else if (sel[IDX_MASK]) bus_rdata = DATA_W'(mask_q);
    else if (sel[IDX_STAT]) bus_rdata = DATA_W'(status);
    else if (sel[IDX_GIN])  bus_rdata = DATA_W'(in_q);
  end
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] bus_addr,
  input logic [3:0]  bus_byte_we,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        bus_pause,
  input logic        uart_tx_valid,
  input logic        uart_tx_ready,
  input logic [7:0]  uart_tx_data,
  input logic        uart_rx_valid,
  input logic        uart_rx_ready,
  input logic [7:0]  uart_rx_data,
  input logic [5:0]  irq_ext,
  input logic        irq,
  input logic [31:0] gpio_out,
  input logic [31:0] gpio_in
);
  logic       reg_area;
  logic [3:0] ix;
  logic       wrc;
  assign reg_area = (bus_addr[31:28] == 4'h2);
  assign ix = bus_addr[7:4];
  assign wrc = (bus_byte_we != 4'h0);

  assert_outside_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !reg_area |-> (bus_rdata == 32'h0 && !uart_tx_valid && !uart_rx_ready));
  assert_tx_offer_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_area && ix == 4'd0 && wrc) |-> (uart_tx_valid && uart_tx_data == bus_wdata[7:0]));
  assert_pause_cause_R3: assert property (@(posedge clk) disable iff (rst)
    bus_pause |-> (reg_area && ix == 4'd0 && wrc && !uart_tx_ready));
  assert_rx_take_R4: assert property (@(posedge clk) disable iff (rst)
    uart_rx_ready |-> (bus_rdata == {24'h0, uart_rx_data}));
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> ({irq_ext, uart_tx_ready, uart_rx_valid} != 8'h0));
  assert_set_bits_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_area && ix == 4'd3 && wrc) |=> (gpio_out == ($past(gpio_out) | $past(bus_wdata))));
  assert_clear_bits_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_area && ix == 4'd4 && wrc) |=> (gpio_out == ($past(gpio_out) & ~$past(bus_wdata))));
  assert_port_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(reg_area && (ix == 4'd3 || ix == 4'd4) && wrc) |=> $stable(gpio_out));
  assert_reset_port_R12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gpio_out == 32'h0));
endmodule

bind periph_regbank regbank_chk chk_i (.*);

// File: tb/periph_regbank_tb_top.sv
module periph_regbank_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] bus_addr = 0;
  logic [3:0]  bus_byte_we = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        bus_pause, uart_tx_valid, uart_rx_ready, irq;
  logic        uart_tx_ready = 1, uart_rx_valid = 0;
  logic [7:0]  uart_tx_data;
  logic [7:0]  uart_rx_data = 0;
  logic [5:0]  irq_ext = 0;
  logic [31:0] gpio_out;
  logic [31:0] gpio_in = 0;

  int errors = 0, checks = 0;
  logic [31:0] m_gpio = 0, m_sample = 0;
  logic [7:0]  m_mask = 0;

  always #2 clk = ~clk;

  periph_regbank dut_i (.*);

  always @(posedge clk) m_sample <= rst ? 32'h0 : gpio_in;

  function automatic logic [7:0] f_status(logic [5:0] e, logic tr, logic rv);
    return {e, tr, rv};
  endfunction
  function automatic logic f_irq(logic [7:0] s, logic [7:0] m);
    return |(s & m);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_byte_we = 4'hF; bus_wdata = d;
    @(posedge clk);
    if (a[31:28] == 4'h2) begin
      case (a[7:4])
        4'd1: m_mask = d[7:0];
        4'd3: m_gpio = m_gpio | d;
        4'd4: m_gpio = m_gpio & ~d;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_byte_we = 4'h0; bus_addr = 32'h0;
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_byte_we = 4'h0;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r, d;
    logic [3:0] ix;
    void'($urandom(32'd1234));
    gpio_in = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset port", gpio_out, 32'h0);
    @(negedge clk); rst = 0;
    rd(32'h2000_0010, r); chk("R12 reset mask", r, 32'h0);

    wr(32'h2000_0030, 32'hFFFF_FFFF);
    wr(32'h2000_0010, 32'h0000_00FF);
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    chk("R12 reset clears set port", gpio_out, 32'h0);
    @(negedge clk); rst = 0; m_gpio = 0; m_mask = 0;
    rd(32'h2000_0010, r); chk("R12 reset clears mask", r, 32'h0);
    rd(32'h2000_0050, r); chk("R10 sample after reset", r, 32'hFFFF_FFFF);

    // R3 stalled transmit write
    @(negedge clk);
    uart_tx_ready = 0;
    bus_addr = 32'h2000_0000; bus_byte_we = 4'hF; bus_wdata = 32'h1234_56A5;
    #1;
    chk("R3 pause while busy", {31'h0, bus_pause}, 32'h1);
    chk("R2 tx valid", {31'h0, uart_tx_valid}, 32'h1);
    chk("R2 tx data", {24'h0, uart_tx_data}, 32'hA5);
    @(negedge clk); #1;
    chk("R3 pause holds", {31'h0, bus_pause}, 32'h1);
    uart_tx_ready = 1; #1;
    chk("R3 pause drops on ready", {31'h0, bus_pause}, 32'h0);
    @(negedge clk); bus_byte_we = 0; bus_addr = 0;
    #1 chk("R3 no pause idle", {31'h0, bus_pause}, 32'h0);

    // R4 receive read
    @(negedge clk);
    uart_rx_data = 8'hC3; uart_rx_valid = 1;
    rd(32'h2000_0000, r);
    chk("R4 rx data", r, 32'h0000_00C3);
    chk("R4 rx ready", {31'h0, uart_rx_ready}, 32'h1);

    // R1 outside region
    wr(32'h3000_0030, 32'hFFFF_FFFF);
    chk("R1 outside write ignored", gpio_out, m_gpio);
    rd(32'h1000_0000, r); chk("R1 outside read zero", r, 32'h0);
    chk("R1 no rx ready outside", {31'h0, uart_rx_ready}, 32'h0);
    @(negedge clk); bus_addr = 32'h0000_0000; bus_byte_we = 4'hF; #1;
    chk("R1 no tx outside", {31'h0, uart_tx_valid}, 32'h0);
    @(negedge clk); bus_byte_we = 0;

    // R6 status write ignored; R11 unmapped
    wr(32'h2000_0010, 32'h0000_005A);
    wr(32'h2000_0020, 32'hFFFF_FFFF);
    rd(32'h2000_0010, r); chk("R6 status write leaves mask", r, 32'h5A);
    chk("R6 status write leaves port", gpio_out, m_gpio);
    wr(32'h2000_00F0, 32'hFFFF_FFFF);
    wr(32'h2000_0060, 32'hFFFF_FFFF);
    rd(32'h2000_0010, r); chk("R11 unmapped write leaves mask", r, 32'h5A);
    chk("R11 unmapped write leaves port", gpio_out, m_gpio);
    rd(32'h2000_0070, r); chk("R11 unmapped read zero", r, 32'h0);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      gpio_in = $urandom; irq_ext = 6'($urandom);
      uart_tx_ready = 1'($urandom); uart_rx_valid = 1'($urandom);
      uart_rx_data = 8'($urandom);
      d = $urandom;
      case ($urandom % 8)
        0: begin wr(32'h2000_0030, d); chk("R8 set bits", gpio_out, m_gpio); end
        1: begin wr(32'h2000_0040, d); chk("R9 clear bits", gpio_out, m_gpio); end
        2: begin wr(32'h2000_0010, d); rd(32'h2000_0010, r);
                 chk("R5 mask readback", r, {24'h0, m_mask}); end
        3: begin rd(32'h2000_0020, r);
                 chk("R6 status read", r, {24'h0, f_status(irq_ext, uart_tx_ready, uart_rx_valid)});
                 chk("R7 irq", {31'h0, irq},
                     {31'h0, f_irq(f_status(irq_ext, uart_tx_ready, uart_rx_valid), m_mask)}); end
        4: begin @(posedge clk); rd(32'h2000_0050, r); chk("R10 input sample", r, m_sample); end
        5: begin ix = 4'(6 + ($urandom % 10));
                 wr({4'h2, 20'($urandom), ix, 4'h0}, d);
                 chk("R11 unmapped write port", gpio_out, m_gpio);
                 rd({4'h2, 20'h0, ix, 4'h0}, r); chk("R11 unmapped read", r, 32'h0); end
        6: begin rd(32'h2000_0000, r); chk("R4 rx read", r, {24'h0, uart_rx_data}); end
        default: begin
                 wr({4'(($urandom % 2) ? 4'h0 : 4'hF), 24'h0, 4'h3, 4'h0}, d);
                 chk("R1 outside write port", gpio_out, m_gpio); end
      endcase
    end

    // R7 directed: single matching bit, then none
    @(negedge clk); uart_tx_ready = 0; uart_rx_valid = 0; irq_ext = 6'b100000;
    wr(32'h2000_0010, 32'h80); #1;
    chk("R7 single match", {31'h0, irq}, 32'h1);
    wr(32'h2000_0010, 32'h7F); #1;
    chk("R7 no match", {31'h0, irq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule